// File: doc/BRIEF.md
# Vector 128-bit lane shuffle unit

This unit assembles a destination vector out of 128-bit slices picked from two source vectors. An 8-bit immediate names the slices. Two vector lengths are handled, 256 and 512 bits. At the full length, the lower half of the result comes from the first source and the upper half from the second. At the short length, one slice is taken from each source and the top half of the result is cleared.

After the shuffle, an optional per-element write mask is applied. An element can be 32 or 64 bits wide. Where the mask denies a write, the element either keeps the previous destination value or is cleared, as chosen by a zeroing flag.

The result is registered, so it appears one clock after the valid strobe. The block sits in a vector execute pipeline. The issue logic upstream supplies the operands already read from the register file.

Top module: `lane_shuffle_unit`

## Requirements
- R1: With `wide_len`=1, result bits [127:0] equal `src_a` slice `imm[1:0]` and bits [255:128] equal `src_a` slice `imm[3:2]`, where slice n means bits [128n+127:128n].
- R2: With `wide_len`=1, result bits [383:256] equal `src_b` slice `imm[5:4]` and bits [511:384] equal `src_b` slice `imm[7:6]`.
- R3: With `wide_len`=0, result bits [127:0] equal `src_a` slice `imm[0]` and bits [255:128] equal `src_b` slice `imm[1]`. Bits [511:256] are zero, and `imm[7:2]` has no effect on the result.
- R4: Any slice may be chosen for several destination slices, in any order.
- R5: With `mask_en`=0, every element receives the shuffled value, and `opmask` and `zero_en` have no effect.
- R6: With `elem64`=0, `opmask` bit j governs result bits [32j+31:32j], for j from 0 to 15.
- R7: With `elem64`=1, `opmask` bit k governs result bits [64k+63:64k], for k from 0 to 7, and `opmask[15:8]` has no effect.
- R8: With `wide_len`=0, only the mask bits covering the low 256 bits are used: bits [7:0] for 32-bit elements and bits [3:0] for 64-bit elements. Bits [511:256] stay zero whatever the mask and `dst_old` hold.
- R9: With `mask_en`=1, an element whose mask bit is 0 takes its `dst_old` value when `zero_en`=0, and becomes zero when `zero_en`=1.
- R10: `out_valid` equals `in_valid` delayed by one clock. Reset clears both `out_valid` and `out_data` to zero.
- R11: While `in_valid` is 0, `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value, used for merging |
| imm | input | 8 | Slice selection immediate |
| wide_len | input | 1 | 1 = 512-bit length, 0 = 256-bit length |
| elem64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| opmask | input | 16 | Per-element write mask |
| mask_en | input | 1 | Apply the write mask |
| zero_en | input | 1 | Masked-off elements become zero instead of keeping dst_old |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_data | output | 512 | Registered result |

## Verification
The assertions take for granted that the control inputs (`wide_len`, `mask_en`, `zero_en`, `opmask`) are known whenever `in_valid` is high. They make no assumption about the inputs while `in_valid` is low, because the result register is then held. The bench changes inputs only at falling edges and always drives every control bit to 0 or 1. It also changes sources and masks freely while `in_valid` is low, to show that those values are not captured.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int VEC_W   = 512;
  localparam int LANE_W  = 128;
  localparam int WORD_W  = 32;
  localparam int N_LANES = VEC_W / LANE_W;
  localparam int N_WORDS = VEC_W / WORD_W;
  localparam int SEL_W   = $clog2(N_LANES);
  localparam int IMM_W   = N_LANES * SEL_W;

  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/lsu_lane_select.sv
module lsu_lane_select #(
  parameter int LANE_W  = lsu_pkg::LANE_W,
  parameter int N_LANES = lsu_pkg::N_LANES,
  localparam int SEL_W  = $clog2(N_LANES),
  localparam int IMM_W  = N_LANES * SEL_W,
  localparam int VEC_W  = LANE_W * N_LANES
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             wide_len,
  output logic [VEC_W-1:0] shuf
);
  localparam int HALF    = N_LANES / 2;
  localparam int QUARTER = N_LANES / 4;
  localparam int NSEL_W  = SEL_W - 1;

  for (genvar d = 0; d < N_LANES; d++) begin : g_lane
    logic [SEL_W-1:0]  idx_w;
    logic [LANE_W-1:0] pick_w;
    assign idx_w = imm[d*SEL_W +: SEL_W];

    if (d < HALF) begin : g_low
      assign pick_w = src_a[int'(idx_w)*LANE_W +: LANE_W];
    end else begin : g_high
      assign pick_w = src_b[int'(idx_w)*LANE_W +: LANE_W];
    end

    if (d < HALF) begin : g_narrow_live
      logic [NSEL_W-1:0] idx_n;
      logic [LANE_W-1:0] pick_n;
      assign idx_n = imm[d*NSEL_W +: NSEL_W];
      if (d < QUARTER) begin : g_na
        assign pick_n = src_a[int'(idx_n)*LANE_W +: LANE_W];
      end else begin : g_nb
        assign pick_n = src_b[int'(idx_n)*LANE_W +: LANE_W];
      end
      assign shuf[d*LANE_W +: LANE_W] = wide_len ? pick_w : pick_n;
    end else begin : g_narrow_dead
      assign shuf[d*LANE_W +: LANE_W] = wide_len ? pick_w : '0;
    end
  end
endmodule

// File: rtl/lsu_mask_merge.sv
module lsu_mask_merge #(
  parameter int WORD_W  = lsu_pkg::WORD_W,
  parameter int N_WORDS = lsu_pkg::N_WORDS,
  localparam int VEC_W  = WORD_W * N_WORDS
) (
  input  logic [VEC_W-1:0]   shuf,
  input  logic [VEC_W-1:0]   dst_old,
  input  logic [N_WORDS-1:0] opmask,
  input  logic               elem64,
  input  logic               wide_len,
  input  logic               mask_en,
  input  logic               zero_en,
  output logic [VEC_W-1:0]   merged
);
  localparam int HALF = N_WORDS / 2;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic live;
    logic wr;
    if (w < HALF) begin : g_lo
      assign live = 1'b1;
    end else begin : g_hi
      assign live = wide_len;
    end
    assign wr = !mask_en || (elem64 ? opmask[w/2] : opmask[w]);

    always_comb begin
      if (!live)
        merged[w*WORD_W +: WORD_W] = '0;
      else if (wr)
        merged[w*WORD_W +: WORD_W] = shuf[w*WORD_W +: WORD_W];
      else if (zero_en)
        merged[w*WORD_W +: WORD_W] = '0;
      else
        merged[w*WORD_W +: WORD_W] = dst_old[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import lsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic [VEC_W-1:0]   dst_old,
  input  logic [IMM_W-1:0]   imm,
  input  logic               wide_len,
  input  logic               elem64,
  input  logic [N_WORDS-1:0] opmask,
  input  logic               mask_en,
  input  logic               zero_en,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_data
);
  vec_t shuf;
  vec_t merged;
  vec_t data_d;
  vec_t data_q;
  logic valid_d;
  logic valid_q;

  lsu_lane_select #(.LANE_W(LANE_W), .N_LANES(N_LANES)) sel_i (
    .src_a    (src_a),
    .src_b    (src_b),
    .imm      (imm),
    .wide_len (wide_len),
    .shuf     (shuf)
  );

  lsu_mask_merge #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) merge_i (
    .shuf     (shuf),
    .dst_old  (dst_old),
    .opmask   (opmask),
    .elem64   (elem64),
    .wide_len (wide_len),
    .mask_en  (mask_en),
    .zero_en  (zero_en),
    .merged   (merged)
  );

  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    if (in_valid) data_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R11
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_len) |=> (out_data[VEC_W-1:VEC_W/2] == '0)); // R8
  AST_ZERO_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && zero_en && opmask == '0) |=> (out_data == '0)); // R9
  AST_UNMASKED_IGNORES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_len && !mask_en && imm == 8'hE4)
      |=> (out_data == {$past(src_b[VEC_W-1:VEC_W/2]), $past(src_a[VEC_W/2-1:0])})); // R5
endmodule

// File: tb/lane_shuffle_unit_tb.sv
module lane_shuffle_unit_tb_top;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] src_a, src_b, dst_old;
  logic [7:0]   imm;
  logic         wide_len, elem64, mask_en, zero_en;
  logic [15:0]  opmask;
  logic         out_valid;
  logic [511:0] out_data;

  int checks;
  int errors;

  lane_shuffle_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .imm(imm),
    .wide_len(wide_len), .elem64(elem64), .opmask(opmask),
    .mask_en(mask_en), .zero_en(zero_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [511:0] rand512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [511:0] model(
    logic [511:0] a, logic [511:0] b, logic [511:0] old, logic [7:0] im,
    logic wide, logic e64, logic [15:0] om, logic men, logic zen);
    logic [511:0] r;
    logic bit_w;
    r = '0;
    if (wide) begin
      r[127:0]   = a[im[1:0]*128 +: 128];
      r[255:128] = a[im[3:2]*128 +: 128];
      r[383:256] = b[im[5:4]*128 +: 128];
      r[511:384] = b[im[7:6]*128 +: 128];
    end else begin
      r[127:0]   = a[im[0]*128 +: 128];
      r[255:128] = b[im[1]*128 +: 128];
    end
    for (int w = 0; w < 16; w++) begin
      bit_w = e64 ? om[w/2] : om[w];
      if (!wide && w >= 8) r[w*32 +: 32] = '0;
      else if (men && !bit_w) r[w*32 +: 32] = zen ? 32'h0 : old[w*32 +: 32];
    end
    return r;
  endfunction

  task automatic check1(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag);
    logic [511:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    exp = model(src_a, src_b, dst_old, imm, wide_len, elem64, opmask, mask_en, zero_en);
    @(negedge clk);
    check1({tag, " valid"}, {511'b0, out_valid}, 512'd1);
    check1(tag, out_data, exp);
    in_valid = 1'b0;
  endtask

  task automatic set_op(logic [7:0] im, logic wide, logic e64, logic [15:0] om,
                        logic men, logic zen);
    imm = im; wide_len = wide; elem64 = e64; opmask = om; mask_en = men; zero_en = zen;
  endtask

  logic [511:0] lanes_a, lanes_b;
  initial begin
    lanes_a = {{4{32'hA3A3A3A3}}, {4{32'hA2A2A2A2}}, {4{32'hA1A1A1A1}}, {4{32'hA0A0A0A0}}};
    lanes_b = {{4{32'hB3B3B3B3}}, {4{32'hB2B2B2B2}}, {4{32'hB1B1B1B1}}, {4{32'hB0B0B0B0}}};
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'd5150));
    checks = 0; errors = 0;
    rst_n = 1'b0; in_valid = 1'b0;
    src_a = '0; src_b = '0; dst_old = '0;
    set_op(8'h00, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check1("R10 reset valid", {511'b0, out_valid}, 512'd0);
    check1("R10 reset data", out_data, 512'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R10 idle valid", {511'b0, out_valid}, 512'd0);

    src_a = lanes_a; src_b = lanes_b; dst_old = {16{32'hDEADBEEF}};
    set_op(8'hE4, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0); run_op("R1 R2 identity");
    set_op(8'h1B, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0); run_op("R1 R2 reversed");
    set_op(8'h00, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0); run_op("R4 all zero slice");
    set_op(8'hFF, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0); run_op("R4 all top slice");
    set_op(8'hFC, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0); run_op("R3 narrow imm junk");
    set_op(8'h03, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0); run_op("R3 narrow high picks");
    set_op(8'hE4, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1); run_op("R5 mask ignored");
    set_op(8'hE4, 1'b1, 1'b0, 16'hA5A5, 1'b1, 1'b0); run_op("R6 R9 merge old");
    set_op(8'hE4, 1'b1, 1'b0, 16'hA5A5, 1'b1, 1'b1); run_op("R6 R9 zeroing");
    set_op(8'hE4, 1'b1, 1'b1, 16'hFF0F, 1'b1, 1'b0); run_op("R7 64-bit mask");
    set_op(8'hE4, 1'b1, 1'b1, 16'hFF0F, 1'b1, 1'b1); run_op("R7 64-bit zeroing");
    set_op(8'h01, 1'b0, 1'b0, 16'h0F3C, 1'b1, 1'b0); run_op("R8 narrow 32-bit mask");
    set_op(8'h02, 1'b0, 1'b1, 16'hFFF5, 1'b1, 1'b0); run_op("R8 narrow 64-bit mask");
    set_op(8'hE4, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1); run_op("R9 all masked zero");

    held = out_data;
    @(negedge clk);
    src_a = rand512(); src_b = rand512(); dst_old = rand512();
    set_op(8'h5A, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b1);
    @(negedge clk);
    check1("R11 hold", out_data, held);
    check1("R10 valid low", {511'b0, out_valid}, 512'd0);

    for (int n = 0; n < 400; n++) begin
      src_a = rand512(); src_b = rand512(); dst_old = rand512();
      set_op($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      if (!wide_len)    run_op("R3 R8 random narrow");
      else if (mask_en) run_op(elem64 ? "R7 R9 random" : "R6 R9 random");
      else              run_op("R1 R2 R4 R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule